// File: doc/BRIEF.md
# Operand Remap Table

This block tells instruction decode how to treat each register operand. It holds two small associative tables that software loads through a CSR-style write port. The first table marks a register as vectorised. Each entry maps a key register to the register that is actually used and to an element width. The second table attaches a predicate to a key register. Each entry names the register that holds the mask, and carries an invert flag and a zeroing flag. Every entry is tagged for either the integer file or the floating-point file.

Decode presents the destination and both sources at once, on three lookup ports. Port 0 is rd, port 1 is rs1 and port 2 is rs2. In the same cycle each port gets back:
- a hit flag;
- the remapped register;
- the element width;
- the predicate fields.

A single all-scalar output tells decode that none of the three operands is vectorised, so the instruction can take the plain scalar path.

Lookups are combinational from the stored table, and writes take effect at the clock edge. Deleting an entry also removes every entry at a higher index in the same table.

Top module: `opnd_remap_table`

## Requirements
- R1: After a synchronous active-low reset, both tables are empty. Every lookup misses, returns its own register number with width code 0, returns zero predicate fields, and `all_scalar` is 1.
- R2: A write with `wr_table`=0 and `wr_del`=0 stores file, key, target register and width code at `wr_idx`. From the next cycle, a lookup with the same file bit and register number hits and returns that target register and width code.
- R3: File bit 0 selects the integer file and 1 selects the floating-point file. A lookup whose file bit differs from the entry's file bit does not match that entry.
- R4: Width codes are 0 (default), 1 (8 bits), 2 (16 bits), 3 (32 bits) and 4 (64 bits). A register entry holding code 5, 6 or 7 never produces a hit.
- R5: A write with `wr_table`=1 stores a predicate entry. A matching lookup then raises `prd_hit` and returns the mask register, the invert flag and the zeroing flag. On a miss these three fields are 0.
- R6: A write with `wr_del`=1 invalidates the entry at `wr_idx` and every entry above it in the selected table. Lower entries and the other table are left unchanged.
- R7: When several usable entries of one table match a lookup, the lowest-indexed entry supplies the result.
- R8: A lookup made in the same cycle as a write sees the table contents from before that write.
- R9: `all_scalar` is 1 exactly when none of the three ports hits the register table. Predicate hits do not affect it.
- R10: The three lookup ports resolve independently in the same cycle. Port p uses bit p of `lk_file` and bits 5p+4..5p of `lk_reg`, and drives the matching slices of each output.
- R11: On a register-table miss, the remapped register equals the looked-up register number and the width code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_table | input | 1 | 0 selects the register table, 1 selects the predicate table |
| wr_del | input | 1 | 1 deletes the entry at wr_idx and all entries above it |
| wr_idx | input | 3 | Entry index |
| wr_file | input | 1 | File tag of the entry (0 integer, 1 floating point) |
| wr_key | input | 5 | Key register number |
| wr_target | input | 5 | Start register (register table) or mask register (predicate table) |
| wr_ew | input | 3 | Element width code (register table only) |
| wr_inv | input | 1 | Invert flag (predicate table only) |
| wr_zero | input | 1 | Zeroing flag (predicate table only) |
| lk_file | input | 3 | File bit per lookup port |
| lk_reg | input | 15 | Register number per lookup port, 5 bits each |
| map_hit | output | 3 | Register-table hit per port |
| map_reg | output | 15 | Remapped register per port |
| map_ew | output | 9 | Element width code per port |
| prd_hit | output | 3 | Predicate-table hit per port |
| prd_reg | output | 15 | Mask register per port |
| prd_inv | output | 3 | Invert flag per port |
| prd_zero | output | 3 | Zeroing flag per port |
| all_scalar | output | 1 | No port hit the register table |

## Verification
The bench keys entries on a small set of register numbers so that duplicate keys are common. A design that resolved duplicates by the highest index, or by the most recent write, would then return the wrong target. Deletes land in the middle of a populated table. A design that cleared only the named slot, or cleared lower slots too, would leave stale hits or lose live ones. Every cycle compares outputs before the clock edge while a write is pending, so a lookup that bypassed the new data would fail. Directed steps cover reserved width codes that must not hit, file-bit mismatches on the same key, and predicate-only hits that must leave `all_scalar` high.

// File: rtl/opnd_remap_pkg.sv
// Package: shared constants and helpers for the operand remap table.
// Assumes 3-bit element width codes; codes above EW_MAX_CODE are reserved.
package opnd_remap_pkg;

    localparam int EW_W = 3;

    typedef enum logic [EW_W-1:0] {
        EW_DEF = 3'd0,
        EW_8   = 3'd1,
        EW_16  = 3'd2,
        EW_32  = 3'd3,
        EW_64  = 3'd4
    } ew_e;

    localparam logic [EW_W-1:0] EW_MAX_CODE = EW_64;

    // True when a width code names a defined element width.
    function automatic logic ew_legal(input logic [EW_W-1:0] code);
        return code <= EW_MAX_CODE;
    endfunction

endpackage

// File: rtl/remap_entry_store.sv
// Module: remap_entry_store
// Holds ENTRIES key-value entries, each with a valid bit, file tag, key
// and an opaque payload. A write fills one slot. A delete clears the named
// slot and every slot above it. Assumes ENTRIES is a power of two that
// matches the index width.
module remap_entry_store #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 5,
    parameter int PAY_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_del,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_file,
    input  logic [KEY_W-1:0]          wr_key,
    input  logic [PAY_W-1:0]          wr_pay,
    output logic [ENTRIES-1:0]        ent_valid,
    output logic [ENTRIES-1:0]        ent_file,
    output logic [ENTRIES*KEY_W-1:0]  ent_key,
    output logic [ENTRIES*PAY_W-1:0]  ent_pay
);

    logic [ENTRIES-1:0] valid_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        // Valid bit of one slot: set on write, cleared on delete at or below it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en) begin
                if (wr_del && (g >= int'(wr_idx))) begin
                    valid_q[g] <= 1'b0;
                end else if (!wr_del && (g == int'(wr_idx))) begin
                    valid_q[g] <= 1'b1;
                end
            end
        end

        // Fields of one slot: loaded on a plain write to this index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_file[g]                 <= 1'b0;
                ent_key[g*KEY_W +: KEY_W]   <= '0;
                ent_pay[g*PAY_W +: PAY_W]   <= '0;
            end else if (wr_en && !wr_del && (g == int'(wr_idx))) begin
                ent_file[g]                 <= wr_file;
                ent_key[g*KEY_W +: KEY_W]   <= wr_key;
                ent_pay[g*PAY_W +: PAY_W]   <= wr_pay;
            end
        end
    end

    assign ent_valid = valid_q;

    // R1: reset empties the store.
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

    // R2: a plain write makes its slot valid.
    a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_del) |=> valid_q[$past(wr_idx)]);

    // R6: a delete clears the named slot and everything above it.
    a_r6_delete_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_del) |=> ((valid_q >> $past(wr_idx)) == '0));

    // R6: a delete leaves lower slots untouched.
    a_r6_delete_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_del) |=>
        (((valid_q ^ $past(valid_q)) & ~({ENTRIES{1'b1}} << $past(wr_idx))) == '0));

endmodule

// File: rtl/remap_search.sv
// Module: remap_search
// Parallel key compare over all entries of one table for one query.
// The lowest-indexed usable entry with a matching file tag and key wins.
// Purely combinational. Assumes the caller has already folded validity and
// any payload legality into ent_use.
module remap_search #(
    parameter int ENTRIES = 8,
    parameter int KEY_W   = 5,
    parameter int PAY_W   = 8
) (
    input  logic [ENTRIES-1:0]        ent_use,
    input  logic [ENTRIES-1:0]        ent_file,
    input  logic [ENTRIES*KEY_W-1:0]  ent_key,
    input  logic [ENTRIES*PAY_W-1:0]  ent_pay,
    input  logic                      q_file,
    input  logic [KEY_W-1:0]          q_key,
    output logic                      hit,
    output logic [PAY_W-1:0]          pay
);

    logic [ENTRIES-1:0] match;

    // Per-entry match vector.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_use[g] && (ent_file[g] == q_file)
                          && (ent_key[g*KEY_W +: KEY_W] == q_key);
    end

    // Priority select: scan downward so the lowest matching index remains.
    always_comb begin
        hit = 1'b0;
        pay = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                pay = ent_pay[i*PAY_W +: PAY_W];
            end
        end
    end

endmodule

// File: rtl/opnd_remap_table.sv
// Module: opnd_remap_table (top)
// Register remap table and predicate table, each loaded through one shared
// write port. PORTS lookup ports search both tables in parallel. Results
// are combinational from the stored contents, so a same-cycle write is not
// visible until the next cycle. Assumes port 0 = rd, 1 = rs1, 2 = rs2.
module opnd_remap_table
    import opnd_remap_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int RW      = 5,
    parameter int PORTS   = 3,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int RPAY_W = RW + EW_W,
    localparam int PPAY_W = RW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_table,
    input  logic                  wr_del,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic                  wr_file,
    input  logic [RW-1:0]         wr_key,
    input  logic [RW-1:0]         wr_target,
    input  logic [EW_W-1:0]       wr_ew,
    input  logic                  wr_inv,
    input  logic                  wr_zero,
    input  logic [PORTS-1:0]      lk_file,
    input  logic [PORTS*RW-1:0]   lk_reg,
    output logic [PORTS-1:0]      map_hit,
    output logic [PORTS*RW-1:0]   map_reg,
    output logic [PORTS*EW_W-1:0] map_ew,
    output logic [PORTS-1:0]      prd_hit,
    output logic [PORTS*RW-1:0]   prd_reg,
    output logic [PORTS-1:0]      prd_inv,
    output logic [PORTS-1:0]      prd_zero,
    output logic                  all_scalar
);

    logic [ENTRIES-1:0]        r_valid, r_file, r_use;
    logic [ENTRIES*RW-1:0]     r_key;
    logic [ENTRIES*RPAY_W-1:0] r_pay;
    logic [ENTRIES-1:0]        p_valid, p_file;
    logic [ENTRIES*RW-1:0]     p_key;
    logic [ENTRIES*PPAY_W-1:0] p_pay;

    remap_entry_store #(.ENTRIES(ENTRIES), .KEY_W(RW), .PAY_W(RPAY_W)) u_reg_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && !wr_table),
        .wr_del    (wr_del),
        .wr_idx    (wr_idx),
        .wr_file   (wr_file),
        .wr_key    (wr_key),
        .wr_pay    ({wr_ew, wr_target}),
        .ent_valid (r_valid),
        .ent_file  (r_file),
        .ent_key   (r_key),
        .ent_pay   (r_pay)
    );

    remap_entry_store #(.ENTRIES(ENTRIES), .KEY_W(RW), .PAY_W(PPAY_W)) u_prd_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en && wr_table),
        .wr_del    (wr_del),
        .wr_idx    (wr_idx),
        .wr_file   (wr_file),
        .wr_key    (wr_key),
        .wr_pay    ({wr_zero, wr_inv, wr_target}),
        .ent_valid (p_valid),
        .ent_file  (p_file),
        .ent_key   (p_key),
        .ent_pay   (p_pay)
    );

    // Register entries with a reserved width code are not usable.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_use
        assign r_use[e] = r_valid[e] && ew_legal(r_pay[e*RPAY_W + RW +: EW_W]);
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic              rh, ph;
        logic [RPAY_W-1:0] rp;
        logic [PPAY_W-1:0] pp;

        remap_search #(.ENTRIES(ENTRIES), .KEY_W(RW), .PAY_W(RPAY_W)) u_reg_search (
            .ent_use  (r_use),
            .ent_file (r_file),
            .ent_key  (r_key),
            .ent_pay  (r_pay),
            .q_file   (lk_file[p]),
            .q_key    (lk_reg[p*RW +: RW]),
            .hit      (rh),
            .pay      (rp)
        );

        remap_search #(.ENTRIES(ENTRIES), .KEY_W(RW), .PAY_W(PPAY_W)) u_prd_search (
            .ent_use  (p_valid),
            .ent_file (p_file),
            .ent_key  (p_key),
            .ent_pay  (p_pay),
            .q_file   (lk_file[p]),
            .q_key    (lk_reg[p*RW +: RW]),
            .hit      (ph),
            .pay      (pp)
        );

        // Register result: remapped start and width on hit, passthrough on miss.
        assign map_hit[p]             = rh;
        assign map_reg[p*RW +: RW]    = rh ? rp[RW-1:0] : lk_reg[p*RW +: RW];
        assign map_ew[p*EW_W +: EW_W] = rh ? rp[RW +: EW_W] : EW_DEF;

        // Predicate result: search returns zeros on a miss.
        assign prd_hit[p]          = ph;
        assign prd_reg[p*RW +: RW] = pp[RW-1:0];
        assign prd_inv[p]          = pp[RW];
        assign prd_zero[p]         = pp[RW+1];

        // R4: a hit never carries a reserved width code.
        a_r4_legal_width: assert property (@(posedge clk) disable iff (!rst_n)
            map_hit[p] |-> ew_legal(map_ew[p*EW_W +: EW_W]));

        // R9/R11: when all operands are scalar each port passes its register through.
        a_r9_scalar_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
            all_scalar |-> ((map_reg[p*RW +: RW] == lk_reg[p*RW +: RW])
                            && (map_ew[p*EW_W +: EW_W] == EW_DEF)));

        // R5: predicate fields are zero on a predicate miss.
        a_r5_pred_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !prd_hit[p] |-> ((prd_reg[p*RW +: RW] == '0) && !prd_inv[p] && !prd_zero[p]));
    end

    // All-scalar detect: no operand hit the register table.
    assign all_scalar = ~|map_hit;

endmodule

// File: tb/opnd_remap_table_bench.sv
module opnd_remap_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int P = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_table = 1'b0, wr_del = 1'b0, wr_file = 1'b0;
    logic [2:0]  wr_idx = '0, wr_ew = '0;
    logic [4:0]  wr_key = '0, wr_target = '0;
    logic        wr_inv = 1'b0, wr_zero = 1'b0;
    logic [2:0]  lk_file = '0;
    logic [14:0] lk_reg = '0;
    logic [2:0]  map_hit, prd_hit, prd_inv, prd_zero;
    logic [14:0] map_reg, prd_reg;
    logic [8:0]  map_ew;
    logic        all_scalar;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference tables, index [table][entry].
    bit       m_val  [2][N];
    bit       m_file [2][N];
    bit [4:0] m_key  [2][N];
    bit [4:0] m_tgt  [2][N];
    bit [2:0] m_ew   [2][N];
    bit       m_inv  [2][N];
    bit       m_zero [2][N];

    opnd_remap_table u_opnd_remap_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_table(wr_table), .wr_del(wr_del),
        .wr_idx(wr_idx), .wr_file(wr_file), .wr_key(wr_key), .wr_target(wr_target),
        .wr_ew(wr_ew), .wr_inv(wr_inv), .wr_zero(wr_zero), .lk_file(lk_file),
        .lk_reg(lk_reg), .map_hit(map_hit), .map_reg(map_reg), .map_ew(map_ew),
        .prd_hit(prd_hit), .prd_reg(prd_reg), .prd_inv(prd_inv), .prd_zero(prd_zero),
        .all_scalar(all_scalar)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run exceeded cycle limit, actual=%0d expected<=100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic model_clear();
        for (int t = 0; t < 2; t++)
            for (int i = 0; i < N; i++) m_val[t][i] = 0;
    endtask

    task automatic model_write();
        int t = int'(wr_table);
        if (!wr_en) return;
        if (wr_del) begin
            for (int i = int'(wr_idx); i < N; i++) m_val[t][i] = 0;
        end else begin
            m_val[t][wr_idx]  = 1;
            m_file[t][wr_idx] = wr_file;
            m_key[t][wr_idx]  = wr_key;
            m_tgt[t][wr_idx]  = wr_target;
            m_ew[t][wr_idx]   = wr_ew;
            m_inv[t][wr_idx]  = wr_inv;
            m_zero[t][wr_idx] = wr_zero;
        end
    endtask

    // Expected register-table result for one query: {hit, ew, reg}.
    function automatic bit [8:0] exp_map(input bit f, input bit [4:0] r);
        for (int i = 0; i < N; i++)
            if (m_val[0][i] && m_ew[0][i] <= 3'd4 && m_file[0][i] == f && m_key[0][i] == r)
                return {1'b1, m_ew[0][i], m_tgt[0][i]};
        return {1'b0, 3'd0, r};
    endfunction

    // Expected predicate-table result: {hit, zero, inv, reg}.
    function automatic bit [7:0] exp_prd(input bit f, input bit [4:0] r);
        for (int i = 0; i < N; i++)
            if (m_val[1][i] && m_file[1][i] == f && m_key[1][i] == r)
                return {1'b1, m_zero[1][i], m_inv[1][i], m_tgt[1][i]};
        return 8'd0;
    endfunction

    task automatic check_all(input string tag);
        bit any = 0;
        for (int p = 0; p < P; p++) begin
            bit [8:0] em = exp_map(lk_file[p], lk_reg[p*5 +: 5]);
            bit [7:0] ep = exp_prd(lk_file[p], lk_reg[p*5 +: 5]);
            bit [8:0] am = {map_hit[p], map_ew[p*3 +: 3], map_reg[p*5 +: 5]};
            bit [7:0] ap = {prd_hit[p], prd_zero[p], prd_inv[p], prd_reg[p*5 +: 5]};
            any |= em[8];
            checks++;
            if (am !== em) begin
                errors++;
                $display("FAIL %s port%0d map: actual=%h expected=%h", tag, p, am, em);
            end
            checks++;
            if (ap !== ep) begin
                errors++;
                $display("FAIL %s port%0d pred: actual=%h expected=%h", tag, p, ap, ep);
            end
        end
        checks++;
        if (all_scalar !== !any) begin
            errors++;
            $display("FAIL %s R9 all_scalar: actual=%b expected=%b", tag, all_scalar, !any);
        end
    endtask

    // Check before the edge (old contents, R8), then clock and update the model.
    task automatic tick(input string tag);
        #1;
        check_all(tag);
        @(posedge clk);
        model_write();
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic set_wr(input bit tbl, input bit del, input int idx, input bit f,
                          input int key, input int tgt, input int ew, input bit inv, input bit zr);
        wr_en = 1; wr_table = tbl; wr_del = del; wr_idx = 3'(idx); wr_file = f;
        wr_key = 5'(key); wr_target = 5'(tgt); wr_ew = 3'(ew); wr_inv = inv; wr_zero = zr;
    endtask

    task automatic set_lk(input bit [2:0] f, input int r0, input int r1, input int r2);
        lk_file = f;
        lk_reg = {5'(r2), 5'(r1), 5'(r0)};
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 / R11: empty table, passthrough.
        set_lk(3'b010, 3, 17, 31);
        tick("R1");

        // R2 with R8: write key 3 -> start 20, width 16; same-cycle lookup sees old.
        set_wr(0, 0, 0, 0, 3, 20, 2, 0, 0);
        set_lk(3'b000, 3, 3, 5);
        tick("R8");
        tick("R2");

        // R3: same key, other file.
        set_lk(3'b111, 3, 3, 3);
        tick("R3");

        // R7: duplicate key at a higher index, lower index wins.
        set_wr(0, 0, 1, 0, 3, 9, 1, 0, 0);
        set_lk(3'b000, 3, 4, 3);
        tick("R7");
        tick("R7");

        // R6: deleting index 0 also drops index 1.
        set_wr(0, 1, 0, 0, 0, 0, 0, 0, 0);
        tick("R6");
        tick("R6");

        // R4: reserved width 5 does not hit; width 4 does.
        set_wr(0, 0, 2, 0, 4, 12, 5, 0, 0);
        set_lk(3'b000, 4, 4, 4);
        tick("R4");
        tick("R4");
        set_wr(0, 0, 2, 0, 4, 12, 4, 0, 0);
        tick("R4");
        tick("R4");

        // R5 / R9: predicate-only hit leaves all_scalar high.
        set_wr(1, 0, 0, 1, 6, 11, 0, 1, 1);
        set_lk(3'b001, 6, 7, 8);
        tick("R5");
        tick("R5");

        // R6: deleting in the predicate table leaves the register table alone.
        set_wr(1, 1, 0, 0, 0, 0, 0, 0, 0);
        set_lk(3'b001, 6, 4, 4);
        tick("R6");
        tick("R6");

        // R10: random mixes with a small key space for duplicates.
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 2 == 0)
                set_wr($urandom % 2, ($urandom % 6) == 0, $urandom % 8, $urandom % 2,
                       $urandom % 8, $urandom % 32, $urandom % 8, $urandom % 2, $urandom % 2);
            set_lk(3'($urandom % 8), $urandom % 10, $urandom % 10, $urandom % 10);
            tick("R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule